// File: doc/BRIEF.md
# GPS Time Real-Time Counter

This block keeps absolute time in the satellite-navigation format: a week count, the number of whole seconds elapsed in the current week, and a 15-bit binary fraction of a second. A tick enable pulsed at the fractional rate (32768 Hz for the default widths) advances the count. The count is uniform: there is no leap-second handling, so every week is exactly 604800 seconds long. When the seconds reach the end of the week they return to zero and the week count steps by one.

Software sets the time by presenting the week, the seconds and the fraction together with a load strobe, so all three fields change on one clock edge. To read the time without tearing, software pulses a capture strobe. This copies every field into shadow registers, which it can then read at leisure. An alarm compares the seconds and the fraction against a programmed value and raises a sticky interrupt flag, so it fires once per week at a chosen instant. A second, coarser timer counts seconds with an 8-bit fraction on its own tick. It can also be loaded in parallel, and the same capture strobe snapshots it. All pins are plain control and status signals. Loads and captures take effect on the edge where they are sampled, with no handshake and no back-pressure.

Top module: `gps_rtc_top`

## Requirements
- R1: After reset the time, the secondary timer, the alarm compare value, every snapshot output and `irq` are all zero.
- R2: Each clock edge that samples `tick` high (and `load` low) adds one to the fraction. An edge with both low changes no field.
- R3: When the fraction is 32767 and a tick is taken, the fraction becomes 0 and the seconds-of-week value increases by one.
- R4: When seconds-of-week is 604799 and the fraction carries, seconds-of-week becomes 0 and the week count increases by one. Seconds-of-week never holds 604800 or more.
- R5: The week count is 16 bits wide and wraps from 65535 to 0.
- R6: On an edge with `load` high, week, seconds-of-week and fraction take `ld_week`, `ld_tow` and `ld_frac` together, and any tick on that edge is ignored. A `ld_tow` of 604800 or more loads 0.
- R7: On an edge with `capture` high, the snapshot outputs take the values the main and secondary counters held just before that edge. Between captures the snapshots do not change.
- R8: With `alarm_en` high, `irq` rises on the edge after a tick has advanced the time to exactly the compare value (`alarm_tow`, `alarm_frac`, stored by an `alarm_wr` edge). It stays high until an edge with `irq_clr` high. If a new match and a clear fall on the same edge, the match wins.
- R9: A match reached through `load`, or while `alarm_en` is low, does not raise `irq`.
- R10: The secondary timer adds one to its 8-bit fraction per `aux_tick`. The fraction wraps from 255 to 0 and adds one to its 16-bit seconds, which wrap from 65535 to 0.
- R11: On an edge with `aux_load` high, both fields of the secondary timer take `aux_ld_sec` and `aux_ld_frac`, and any `aux_tick` on that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Fraction-rate advance enable |
| load | input | 1 | Parallel load strobe for the main time |
| ld_week | input | 16 | Week value to load |
| ld_tow | input | 20 | Seconds-of-week value to load |
| ld_frac | input | 15 | Fraction value to load |
| capture | input | 1 | Snapshot strobe for both timers |
| snap_week | output | 16 | Captured week |
| snap_tow | output | 20 | Captured seconds-of-week |
| snap_frac | output | 15 | Captured fraction |
| aux_tick | input | 1 | Advance enable of the secondary timer |
| aux_load | input | 1 | Parallel load strobe for the secondary timer |
| aux_ld_sec | input | 16 | Secondary seconds to load |
| aux_ld_frac | input | 8 | Secondary fraction to load |
| snap_aux_sec | output | 16 | Captured secondary seconds |
| snap_aux_frac | output | 8 | Captured secondary fraction |
| alarm_wr | input | 1 | Stores the alarm compare value |
| alarm_tow | input | 20 | Alarm seconds-of-week |
| alarm_frac | input | 15 | Alarm fraction |
| alarm_en | input | 1 | Alarm enable level |
| irq_clr | input | 1 | Clears the alarm flag |
| irq | output | 1 | Sticky alarm flag |

## Verification
Some properties are checked on every cycle. Seconds-of-week stays inside the week. Nothing moves without a tick or load. A load sets the fields on the next edge. A fraction carry steps the seconds. Snapshots and the flag hold between their strobes, and a disabled alarm never raises the flag. Other behaviour needs the bench's scenarios to show it. These cover the full chain of carries into the week and the week wrap, and clamping of an out-of-range load. They also cover the one-edge delay of the alarm and set winning over clear, along with loading into the compare value without an alarm and the wrap of the secondary timer. Random steps near the end of the week compare every capture and the flag against a bench model.

// File: rtl/gps_rtc_pkg.sv
package gps_rtc_pkg;
  localparam int WEEK_W_D       = 16;
  localparam int TOW_W_D        = 20;
  localparam int FRAC_W_D       = 15;
  localparam int SEC_PER_WEEK_D = 604800;
  localparam int AUX_SEC_W_D    = 16;
  localparam int AUX_FRAC_W_D   = 8;

  // Highest value a counter stage holds; modulus 0 means a full binary range.
  function automatic longint stage_last(int w, int modulus);
    return (modulus == 0) ? ((longint'(1) << w) - 1) : (longint'(modulus) - 1);
  endfunction
endpackage

// File: rtl/gps_rtc_stage.sv
module gps_rtc_stage
  import gps_rtc_pkg::*;
#(
  parameter int W       = 8,
  parameter int MODULUS = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] LAST = W'(stage_last(W, MODULUS));

  logic [W-1:0] ld_safe;
  logic [W-1:0] stepped;

  generate
    if (MODULUS == 0) begin : g_binary
      // Full binary range: wrap by overflow, every load value is legal.
      assign ld_safe = ld_val;
      assign stepped = val + W'(1);
    end else begin : g_modulo
      // Explicit modulus: wrap at LAST, out-of-range loads clamp to zero.
      assign ld_safe = (ld_val > LAST) ? '0 : ld_val;
      assign stepped = (val == LAST) ? '0 : val + W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val <= '0;
    else if (load)  val <= ld_safe;
    else if (inc)   val <= stepped;
  end
endmodule

// File: rtl/gps_time_chain.sv
module gps_time_chain
  import gps_rtc_pkg::*;
#(
  parameter int WEEK_W       = WEEK_W_D,
  parameter int TOW_W        = TOW_W_D,
  parameter int FRAC_W       = FRAC_W_D,
  parameter int SEC_PER_WEEK = SEC_PER_WEEK_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [WEEK_W-1:0] ld_week,
  input  logic [TOW_W-1:0]  ld_tow,
  input  logic [FRAC_W-1:0] ld_frac,
  output logic [WEEK_W-1:0] week,
  output logic [TOW_W-1:0]  tow,
  output logic [FRAC_W-1:0] frac,
  output logic              advanced
);
  localparam logic [FRAC_W-1:0] FRAC_LAST = FRAC_W'(stage_last(FRAC_W, 0));
  localparam logic [TOW_W-1:0]  TOW_LAST  = TOW_W'(stage_last(TOW_W, SEC_PER_WEEK));

  logic tow_inc;
  logic week_inc;

  assign tow_inc  = tick && (frac == FRAC_LAST);
  assign week_inc = tow_inc && (tow == TOW_LAST);

  gps_rtc_stage #(.W(FRAC_W), .MODULUS(0)) i_frac (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_frac), .inc(tick), .val(frac)
  );

  gps_rtc_stage #(.W(TOW_W), .MODULUS(SEC_PER_WEEK)) i_tow (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_tow), .inc(tow_inc), .val(tow)
  );

  gps_rtc_stage #(.W(WEEK_W), .MODULUS(0)) i_week (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_week), .inc(week_inc), .val(week)
  );

  // Marks that the current value was reached by counting, not by loading.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) advanced <= 1'b0;
    else        advanced <= tick && !load;
  end
endmodule

// File: rtl/gps_aux_timer.sv
module gps_aux_timer
  import gps_rtc_pkg::*;
#(
  parameter int SEC_W  = AUX_SEC_W_D,
  parameter int FRAC_W = AUX_FRAC_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [SEC_W-1:0]  ld_sec,
  input  logic [FRAC_W-1:0] ld_frac,
  output logic [SEC_W-1:0]  sec,
  output logic [FRAC_W-1:0] frac
);
  localparam logic [FRAC_W-1:0] FRAC_LAST = FRAC_W'(stage_last(FRAC_W, 0));

  logic sec_inc;
  assign sec_inc = tick && (frac == FRAC_LAST);

  gps_rtc_stage #(.W(FRAC_W), .MODULUS(0)) i_frac (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_frac), .inc(tick), .val(frac)
  );

  gps_rtc_stage #(.W(SEC_W), .MODULUS(0)) i_sec (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_sec), .inc(sec_inc), .val(sec)
  );
endmodule

// File: rtl/gps_alarm.sv
module gps_alarm #(
  parameter int TOW_W  = 20,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [TOW_W-1:0]  cmp_tow_in,
  input  logic [FRAC_W-1:0] cmp_frac_in,
  input  logic              en,
  input  logic              clr,
  input  logic              advanced,
  input  logic [TOW_W-1:0]  tow,
  input  logic [FRAC_W-1:0] frac,
  output logic              irq
);
  logic [TOW_W-1:0]  cmp_tow;
  logic [FRAC_W-1:0] cmp_frac;
  logic              hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_tow  <= '0;
      cmp_frac <= '0;
    end else if (wr) begin
      cmp_tow  <= cmp_tow_in;
      cmp_frac <= cmp_frac_in;
    end
  end

  // A hit needs the time to have been counted into the compare value.
  assign hit = en && advanced && (tow == cmp_tow) && (frac == cmp_frac);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (hit) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end
endmodule

// File: rtl/gps_snap.sv
module gps_snap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/gps_rtc_top.sv
module gps_rtc_top
  import gps_rtc_pkg::*;
#(
  parameter int WEEK_W       = WEEK_W_D,
  parameter int TOW_W        = TOW_W_D,
  parameter int FRAC_W       = FRAC_W_D,
  parameter int SEC_PER_WEEK = SEC_PER_WEEK_D,
  parameter int AUX_SEC_W    = AUX_SEC_W_D,
  parameter int AUX_FRAC_W   = AUX_FRAC_W_D
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  load,
  input  logic [WEEK_W-1:0]     ld_week,
  input  logic [TOW_W-1:0]      ld_tow,
  input  logic [FRAC_W-1:0]     ld_frac,
  input  logic                  capture,
  output logic [WEEK_W-1:0]     snap_week,
  output logic [TOW_W-1:0]      snap_tow,
  output logic [FRAC_W-1:0]     snap_frac,
  input  logic                  aux_tick,
  input  logic                  aux_load,
  input  logic [AUX_SEC_W-1:0]  aux_ld_sec,
  input  logic [AUX_FRAC_W-1:0] aux_ld_frac,
  output logic [AUX_SEC_W-1:0]  snap_aux_sec,
  output logic [AUX_FRAC_W-1:0] snap_aux_frac,
  input  logic                  alarm_wr,
  input  logic [TOW_W-1:0]      alarm_tow,
  input  logic [FRAC_W-1:0]     alarm_frac,
  input  logic                  alarm_en,
  input  logic                  irq_clr,
  output logic                  irq
);
  localparam int MAIN_W = WEEK_W + TOW_W + FRAC_W;
  localparam int AUX_W  = AUX_SEC_W + AUX_FRAC_W;
  localparam int SNAP_W = MAIN_W + AUX_W;

  logic [WEEK_W-1:0]     cur_week;
  logic [TOW_W-1:0]      cur_tow;
  logic [FRAC_W-1:0]     cur_frac;
  logic                  advanced;
  logic [AUX_SEC_W-1:0]  aux_sec;
  logic [AUX_FRAC_W-1:0] aux_frac;
  logic [SNAP_W-1:0]     snap_q;

  gps_time_chain #(
    .WEEK_W(WEEK_W), .TOW_W(TOW_W), .FRAC_W(FRAC_W), .SEC_PER_WEEK(SEC_PER_WEEK)
  ) i_chain (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .ld_week(ld_week), .ld_tow(ld_tow), .ld_frac(ld_frac),
    .week(cur_week), .tow(cur_tow), .frac(cur_frac), .advanced(advanced)
  );

  gps_aux_timer #(.SEC_W(AUX_SEC_W), .FRAC_W(AUX_FRAC_W)) i_aux (
    .clk(clk), .rst_n(rst_n), .tick(aux_tick), .load(aux_load),
    .ld_sec(aux_ld_sec), .ld_frac(aux_ld_frac), .sec(aux_sec), .frac(aux_frac)
  );

  gps_alarm #(.TOW_W(TOW_W), .FRAC_W(FRAC_W)) i_alarm (
    .clk(clk), .rst_n(rst_n), .wr(alarm_wr), .cmp_tow_in(alarm_tow),
    .cmp_frac_in(alarm_frac), .en(alarm_en), .clr(irq_clr),
    .advanced(advanced), .tow(cur_tow), .frac(cur_frac), .irq(irq)
  );

  // One shadow register across both timers keeps a capture coherent.
  gps_snap #(.W(SNAP_W)) i_snap (
    .clk(clk), .rst_n(rst_n), .cap(capture),
    .d({cur_week, cur_tow, cur_frac, aux_sec, aux_frac}),
    .q(snap_q)
  );

  assign {snap_week, snap_tow, snap_frac, snap_aux_sec, snap_aux_frac} = snap_q;
endmodule

// File: rtl/gps_rtc_checker.sv
module gps_rtc_checker #(
  parameter int WEEK_W       = 16,
  parameter int TOW_W        = 20,
  parameter int FRAC_W       = 15,
  parameter int SEC_PER_WEEK = 604800,
  parameter int AUX_SEC_W    = 16,
  parameter int AUX_FRAC_W   = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  load,
  input logic [WEEK_W-1:0]     ld_week,
  input logic [FRAC_W-1:0]     ld_frac,
  input logic                  capture,
  input logic [WEEK_W-1:0]     snap_week,
  input logic [TOW_W-1:0]      snap_tow,
  input logic [FRAC_W-1:0]     snap_frac,
  input logic                  aux_load,
  input logic [AUX_SEC_W-1:0]  aux_ld_sec,
  input logic [AUX_FRAC_W-1:0] aux_ld_frac,
  input logic                  alarm_en,
  input logic                  irq_clr,
  input logic                  irq,
  input logic [WEEK_W-1:0]     cur_week,
  input logic [TOW_W-1:0]      cur_tow,
  input logic [FRAC_W-1:0]     cur_frac,
  input logic [AUX_SEC_W-1:0]  aux_sec,
  input logic [AUX_FRAC_W-1:0] aux_frac
);
  localparam logic [FRAC_W-1:0] FRAC_LAST = '1;
  localparam logic [TOW_W-1:0]  TOW_LIM   = TOW_W'(SEC_PER_WEEK);

  a_r4_tow_in_week: assert property (@(posedge clk) disable iff (!rst_n)
    cur_tow < TOW_LIM);

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !load |=> $stable(cur_frac) && $stable(cur_tow) && $stable(cur_week));

  a_r6_parallel_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_week == $past(ld_week)) && (cur_frac == $past(ld_frac)));

  a_r3_frac_carry: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && (cur_frac == FRAC_LAST) |=> (cur_frac == '0) && (cur_tow != $past(cur_tow)));

  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(snap_week) && $stable(snap_tow) && $stable(snap_frac));

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en && !irq |=> !irq);

  a_r11_aux_load: assert property (@(posedge clk) disable iff (!rst_n)
    aux_load |=> (aux_sec == $past(aux_ld_sec)) && (aux_frac == $past(aux_ld_frac)));
endmodule

bind gps_rtc_top gps_rtc_checker #(
  .WEEK_W(WEEK_W), .TOW_W(TOW_W), .FRAC_W(FRAC_W), .SEC_PER_WEEK(SEC_PER_WEEK),
  .AUX_SEC_W(AUX_SEC_W), .AUX_FRAC_W(AUX_FRAC_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .ld_week(ld_week),
  .ld_frac(ld_frac), .capture(capture), .snap_week(snap_week),
  .snap_tow(snap_tow), .snap_frac(snap_frac), .aux_load(aux_load),
  .aux_ld_sec(aux_ld_sec), .aux_ld_frac(aux_ld_frac), .alarm_en(alarm_en),
  .irq_clr(irq_clr), .irq(irq), .cur_week(cur_week), .cur_tow(cur_tow),
  .cur_frac(cur_frac), .aux_sec(aux_sec), .aux_frac(aux_frac)
);

// File: tb/test_gps_rtc_top.sv
module test_gps_rtc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, load = 1'b0, capture = 1'b0;
  logic [15:0] ld_week = '0;
  logic [19:0] ld_tow = '0;
  logic [14:0] ld_frac = '0;
  logic [15:0] snap_week;
  logic [19:0] snap_tow;
  logic [14:0] snap_frac;
  logic        aux_tick = 1'b0, aux_load = 1'b0;
  logic [15:0] aux_ld_sec = '0;
  logic [7:0]  aux_ld_frac = '0;
  logic [15:0] snap_aux_sec;
  logic [7:0]  snap_aux_frac;
  logic        alarm_wr = 1'b0, alarm_en = 1'b0, irq_clr = 1'b0;
  logic [19:0] alarm_tow = '0;
  logic [14:0] alarm_frac = '0;
  logic        irq;

  int total = 0;
  int fails = 0;

  // Bench model state
  logic [15:0] m_w = '0, s_w = '0, m_as = '0, s_as = '0;
  logic [19:0] m_t = '0, s_t = '0, c_t = '0;
  logic [14:0] m_f = '0, s_f = '0, c_f = '0;
  logic [7:0]  m_af = '0, s_af = '0;
  logic        m_irq = 1'b0, m_adv = 1'b0;

  always #5 clk = ~clk;

  gps_rtc_top i_gps_rtc_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .ld_week(ld_week),
    .ld_tow(ld_tow), .ld_frac(ld_frac), .capture(capture),
    .snap_week(snap_week), .snap_tow(snap_tow), .snap_frac(snap_frac),
    .aux_tick(aux_tick), .aux_load(aux_load), .aux_ld_sec(aux_ld_sec),
    .aux_ld_frac(aux_ld_frac), .snap_aux_sec(snap_aux_sec),
    .snap_aux_frac(snap_aux_frac), .alarm_wr(alarm_wr), .alarm_tow(alarm_tow),
    .alarm_frac(alarm_frac), .alarm_en(alarm_en), .irq_clr(irq_clr), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // One clock: model update at the edge, checks 1 ns later, strobes dropped at negedge.
  task automatic step();
    logic cap_now;
    logic hit;
    @(posedge clk);
    cap_now = capture;
    if (capture) begin
      s_w = m_w; s_t = m_t; s_f = m_f; s_as = m_as; s_af = m_af;
    end
    hit = m_adv && alarm_en && (m_t == c_t) && (m_f == c_f);
    if (hit) m_irq = 1'b1;
    else if (irq_clr) m_irq = 1'b0;
    m_adv = tick && !load;
    if (alarm_wr) begin c_t = alarm_tow; c_f = alarm_frac; end
    if (load) begin
      m_w = ld_week; m_f = ld_frac;
      m_t = (ld_tow < 20'd604800) ? ld_tow : 20'd0;
    end else if (tick) begin
      if (m_f == 15'd32767) begin
        m_f = '0;
        if (m_t == 20'd604799) begin m_t = '0; m_w = m_w + 16'd1; end
        else m_t = m_t + 20'd1;
      end else m_f = m_f + 15'd1;
    end
    if (aux_load) begin m_as = aux_ld_sec; m_af = aux_ld_frac; end
    else if (aux_tick) begin
      if (m_af == 8'd255) m_as = m_as + 16'd1;
      m_af = m_af + 8'd1;
    end
    #1;
    chk("R8 irq flag", 32'(irq), 32'(m_irq));
    if (cap_now) begin
      chk("R7 snap_week", 32'(snap_week), 32'(s_w));
      chk("R7 snap_tow", 32'(snap_tow), 32'(s_t));
      chk("R7 snap_frac", 32'(snap_frac), 32'(s_f));
      chk("R7 snap_aux_sec", 32'(snap_aux_sec), 32'(s_as));
      chk("R7 snap_aux_frac", 32'(snap_aux_frac), 32'(s_af));
    end
    @(negedge clk);
    tick = 0; load = 0; capture = 0; aux_tick = 0; aux_load = 0;
    alarm_wr = 0; irq_clr = 0;
  endtask

  task automatic do_load(logic [15:0] w, logic [19:0] t, logic [14:0] f, logic with_tick);
    load = 1; ld_week = w; ld_tow = t; ld_frac = f; tick = with_tick;
    step();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); end
  endtask

  task automatic cap_main(string tag, logic [15:0] w, logic [19:0] t, logic [14:0] f);
    capture = 1;
    step();
    chk({tag, " week"}, 32'(snap_week), 32'(w));
    chk({tag, " tow"}, 32'(snap_tow), 32'(t));
    chk({tag, " frac"}, 32'(snap_frac), 32'(f));
  endtask

  task automatic cap_aux(string tag, logic [15:0] s, logic [7:0] f);
    capture = 1;
    step();
    chk({tag, " aux sec"}, 32'(snap_aux_sec), 32'(s));
    chk({tag, " aux frac"}, 32'(snap_aux_frac), 32'(f));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state at the ports
    chk("R1 irq after reset", 32'(irq), 32'd0);
    chk("R1 snap_tow after reset", 32'(snap_tow), 32'd0);
    chk("R1 snap_aux_sec after reset", 32'(snap_aux_sec), 32'd0);
    cap_main("R1 capture after reset", 16'd0, 20'd0, 15'd0);
    cap_aux("R1 capture after reset", 16'd0, 8'd0);

    // R2: counting and holding
    ticks(5);
    cap_main("R2 five ticks", 16'd0, 20'd0, 15'd5);
    step(); step();
    cap_main("R2 no tick hold", 16'd0, 20'd0, 15'd5);

    // R3: fraction carry
    do_load(16'd3, 20'd10, 15'd32767, 1'b0);
    ticks(1);
    cap_main("R3 fraction carry", 16'd3, 20'd11, 15'd0);

    // R6: load wins over tick; R4/R5: end of week and week wrap
    do_load(16'd65535, 20'd604799, 15'd32766, 1'b1);
    cap_main("R6 load over tick", 16'd65535, 20'd604799, 15'd32766);
    ticks(1);
    ticks(1);
    cap_main("R4 R5 week rollover", 16'd0, 20'd0, 15'd0);
    do_load(16'd7, 20'd604799, 15'd32767, 1'b0);
    ticks(1);
    cap_main("R4 week step", 16'd8, 20'd0, 15'd0);
    do_load(16'd9, 20'd604800, 15'd4, 1'b0);
    cap_main("R6 out-of-range load", 16'd9, 20'd0, 15'd4);

    // R10, R11: secondary timer
    aux_load = 1; aux_ld_sec = 16'd7; aux_ld_frac = 8'd254; aux_tick = 1; step();
    cap_aux("R11 aux load over tick", 16'd7, 8'd254);
    aux_tick = 1; step(); aux_tick = 1; step();
    cap_aux("R10 aux carry", 16'd8, 8'd0);
    aux_load = 1; aux_ld_sec = 16'd65535; aux_ld_frac = 8'd255; step();
    aux_tick = 1; step();
    cap_aux("R10 aux wrap", 16'd0, 8'd0);

    // R8: alarm one edge after the counted match, sticky, set beats clear
    alarm_en = 1;
    alarm_wr = 1; alarm_tow = 20'd100; alarm_frac = 15'd3; step();
    do_load(16'd1, 20'd100, 15'd2, 1'b0);
    ticks(1);
    chk("R8 no flag on match edge", 32'(irq), 32'd0);
    step();
    chk("R8 flag after match", 32'(irq), 32'd1);
    step(); step();
    chk("R8 flag sticky", 32'(irq), 32'd1);
    irq_clr = 1; step();
    chk("R8 flag cleared", 32'(irq), 32'd0);
    do_load(16'd1, 20'd100, 15'd2, 1'b0);
    ticks(1);
    irq_clr = 1; step();
    chk("R8 set beats clear", 32'(irq), 32'd1);
    irq_clr = 1; step();

    // R9: load into the compare value, or disabled alarm
    do_load(16'd1, 20'd100, 15'd3, 1'b0);
    step(); step();
    chk("R9 load into match", 32'(irq), 32'd0);
    alarm_en = 0;
    do_load(16'd1, 20'd100, 15'd2, 1'b0);
    ticks(1);
    step();
    chk("R9 disabled alarm", 32'(irq), 32'd0);

    // Random phase near boundaries, every result checked against the model
    for (int n = 0; n < 4000; n++) begin
      tick = ($urandom % 2) == 0;
      capture = ($urandom % 5) == 0;
      aux_tick = ($urandom % 2) == 0;
      irq_clr = ($urandom % 20) == 0;
      if (($urandom % 64) == 0) alarm_en = ~alarm_en;
      if (($urandom % 30) == 0) begin
        load = 1;
        ld_week = ($urandom % 2) ? 16'd65535 : 16'($urandom);
        case ($urandom % 4)
          0: ld_tow = 20'd604799;
          1: ld_tow = 20'(604800 + ($urandom % 1000));
          2: ld_tow = 20'($urandom % 604800);
          default: ld_tow = 20'd604798;
        endcase
        ld_frac = ($urandom % 2) ? 15'(32760 + ($urandom % 8)) : 15'($urandom);
      end
      if (($urandom % 30) == 0) begin
        aux_load = 1;
        aux_ld_sec = 16'($urandom);
        aux_ld_frac = 8'(250 + ($urandom % 6));
      end
      if (($urandom % 40) == 0) begin
        alarm_wr = 1;
        alarm_tow = m_t;
        alarm_frac = (m_f < 15'd32760) ? m_f + 15'(1 + ($urandom % 4)) : 15'd2;
      end
      step();
    end

    summary();
    $finish;
  end
endmodule